// File: doc/BRIEF.md
# Cyclic Waveform Buffer with Snapshot and Playback

The block is a per-channel circular sample store for a digitizing trigger board. In recording it writes every converter sample into a ring of `DEPTH` locations, one per clock, so it always holds the most recent stretch of history. The default is 512 samples of 10 bits, which covers about 5 µs at a 10 ns sample period. A stop command can be followed by a programmable number of further samples. After those samples the ring freezes. The write pointer then stays where it stopped, so the bus sees the snapshot ordered from the oldest sample (address 0) to the newest (address `DEPTH-1`).

In playback (source) mode the ring is loaded from the bus at physical addresses. It is then read out continuously, one location per clock, wrapping at the end, and it drives the sample output to the processing logic in place of live converter data. Recorded or simulated events can be replayed this way. Outside source mode the sample output carries the converter input delayed by one register. Start, stop and sync controls are distributed to all channels. Sync realigns the physical write position and the playback position to location 0.

Top module: `cyc_wave_buf`

## Requirements
- R1: During reset and on the first clock after it, `smp_out` is 0, `frozen` is 0, `bus_rvalid` is 0 and `bus_busy` is 0. The buffer leaves reset in the idle state and records nothing until `run_start` is sampled.
- R2: If `src_mode` was 0 two clocks before, `smp_out` equals the `smp_in` value sampled at the previous clock edge.
- R3: After `run_start` has been sampled in the idle or frozen state, every following clock writes `smp_in` into the ring and advances the write position modulo `DEPTH`. Older contents are overwritten.
- R4: When `run_stop` is sampled while recording, the sample of that clock is written, and then exactly `post_stop_len` more samples are written. `frozen` is 1 from the clock after the last write. When `post_stop_len` is 0, `frozen` rises on the clock after the stop. A stop sampled during the post-stop countdown has no effect.
- R5: While frozen, and outside source mode, a read of bus address `k` returns the k-th oldest sample of the snapshot. Address 0 is the oldest sample and `DEPTH-1` is the last one written. `bus_rvalid` is 1 one clock after `bus_rd`, with `bus_busy` 0.
- R6: A read issued while not frozen, or while in source mode, returns `bus_rvalid`=1 with `bus_busy`=1 and `bus_rdata`=0 one clock later.
- R7: While frozen, converter samples, `run_stop` and `run_sync` leave the snapshot unchanged. A later `run_start` resumes recording at the held write position.
- R8: A `run_sync` sampled while recording writes that clock's sample to physical location 0 and continues from location 1. A sync sampled while idle sets the next write location to 0.
- R9: In source mode (`src_mode` registered one clock), a `bus_wr` stores `bus_wdata` at physical location `bus_addr`, and converter samples and run controls are ignored. Starting on the second clock after `src_mode` rises, `smp_out` plays locations 0, 1, 2 and so on, one per clock, wrapping from `DEPTH-1` to 0. A location written in the same clock as it is played shows its old value.
- R10: A `run_sync` sampled in source mode makes the location played on the next-but-one clock equal to 0.
- R11: When `src_mode` falls, `smp_out` returns to live samples from the second clock on. The recording state that was held during source mode resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_in | input | DATA_W | Converter sample |
| run_start | input | 1 | Begin or resume recording |
| run_stop | input | 1 | Request freeze after the post-stop count |
| run_sync | input | 1 | Realign write or playback position to location 0 |
| src_mode | input | 1 | 1 selects playback of bus-loaded data |
| post_stop_len | input | CNT_W | Samples still written after a stop |
| smp_out | output | DATA_W | Sample to the processing logic |
| frozen | output | 1 | Snapshot held |
| bus_addr | input | AW | Bus address (relative to oldest on read, physical on write) |
| bus_wr | input | 1 | Bus write strobe (source mode only) |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rd | input | 1 | Bus read strobe |
| bus_rdata | output | DATA_W | Read data, 0 unless a valid read response |
| bus_rvalid | output | 1 | Read response present |
| bus_busy | output | 1 | Read refused because the buffer is not frozen |

## Verification
The bench runs the ring well past one full wrap before each freeze. A design that mislatched the write pointer would then return a snapshot rotated by one or more places, with address 0 no longer the oldest sample. It tests post-stop counts of 0, 1 and 5, and stops and syncs issued while frozen. An off-by-one countdown would shift the whole snapshot, and a freeze that leaked writes would corrupt it. Playback is run across the wrap, restarted by a sync, and entered after a recording that included a mid-run sync. This exposes wrong wrap points, missing realignment, and physical versus relative addressing mix-ups. Reads while recording and while in source mode must come back flagged busy and carry zero data. Leaving source mode must return live samples with the correct two-clock turnover.

// File: rtl/cwb_pkg.sv
// Shared types for the cyclic waveform buffer.
// Assumes: nothing beyond the standard language.
package cwb_pkg;

    // Recording states: idle, recording, post-stop countdown, frozen snapshot
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REC    = 2'd1,
        ST_POST   = 2'd2,
        ST_FROZEN = 2'd3
    } rec_state_e;

endpackage

// File: rtl/cwb_mem.sv
// Sample ring storage: one synchronous write port and one registered read port.
// Assumes: a read and a write to the same location in one clock return the
// old contents (read-before-write). The array itself is not reset.
module cwb_mem #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 512,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] ram [DEPTH];

    // Write the addressed location when enabled
    always_ff @(posedge clk) begin
        if (we) begin
            ram[waddr] <= wdata;
        end
    end

    // Register the addressed location every clock
    always_ff @(posedge clk) begin
        rdata <= ram[raddr];
    end

endmodule

// File: rtl/cwb_ctrl.sv
// Recording controller: start/stop/sync handling, write pointer, post-stop
// countdown and freeze. Requirements R3, R4, R7, R8.
// Assumes: en is low in source mode, which holds all state unchanged.
module cwb_ctrl
    import cwb_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int CNT_W = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic             stop,
    input  logic             sync,
    input  logic [CNT_W-1:0] post_len,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [AW-1:0]    wptr,
    output logic             frozen,
    output logic             in_post
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rec_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    wr_next;

    // Write strobe and location: sync forces location 0 (R8)
    always_comb begin
        wr_en   = en && ((st == ST_REC) || (st == ST_POST));
        wr_addr = sync ? '0 : wptr;
        wr_next = (wr_addr == LAST) ? '0 : wr_addr + 1'b1;
    end

    // State, write pointer and countdown sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            wptr <= '0;
            cnt  <= '0;
        end else if (en) begin
            unique case (st)
                ST_IDLE: begin
                    if (sync) begin
                        wptr <= '0;
                    end
                    if (start) begin
                        st <= ST_REC;
                    end
                end
                ST_REC: begin
                    wptr <= wr_next;
                    if (stop) begin
                        if (post_len == '0) begin
                            st <= ST_FROZEN;
                        end else begin
                            cnt <= post_len;
                            st  <= ST_POST;
                        end
                    end
                end
                ST_POST: begin
                    wptr <= wr_next;
                    cnt  <= cnt - 1'b1;
                    if (cnt == CNT_W'(1)) begin
                        st <= ST_FROZEN;
                    end
                end
                ST_FROZEN: begin
                    if (start) begin
                        st <= ST_REC;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Status decodes for the rest of the block
    always_comb begin
        frozen  = (st == ST_FROZEN);
        in_post = (st == ST_POST);
    end

endmodule

// File: rtl/cwb_play.sv
// Playback pointer for source mode: restarts at 0 on entry and on sync,
// steps one location per clock and wraps at DEPTH-1. Requirements R9, R10.
// Assumes: src_q is the registered source-mode select.
module cwb_play #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_q,
    input  logic          sync,
    output logic [AW-1:0] play_ptr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Advance or restart the playback location
    always_ff @(posedge clk) begin
        if (!rst_n || !src_q || sync) begin
            play_ptr <= '0;
        end else if (play_ptr == LAST) begin
            play_ptr <= '0;
        end else begin
            play_ptr <= play_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/cwb_port.sv
// Bus read side: selects the ring read location (playback or snapshot
// relative to the oldest sample) and forms the read response. R5, R6.
// Assumes: mem_rdata is the registered ring output for last clock's raddr.
module cwb_port #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 512,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic              frozen,
    input  logic              src_q,
    input  logic [AW-1:0]     wptr,
    input  logic [AW-1:0]     play_ptr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_busy
);

    logic [AW-1:0] snap_addr;
    logic          busy_q;

    // Snapshot location: oldest sample sits at the held write pointer
    generate
        if (DEPTH == (1 << AW)) begin : g_pow2
            always_comb snap_addr = wptr + bus_addr;
        end else begin : g_mod
            logic [AW:0] sum;
            always_comb begin
                sum       = {1'b0, wptr} + {1'b0, bus_addr};
                snap_addr = (sum >= (AW+1)'(DEPTH)) ? AW'(sum - (AW+1)'(DEPTH)) : sum[AW-1:0];
            end
        end
    endgenerate

    // Ring read location: playback owns the port in source mode
    always_comb raddr = src_q ? play_ptr : snap_addr;

    // Read response: valid one clock later, refused unless frozen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            busy_q     <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            busy_q     <= bus_rd && !(frozen && !src_q);
        end
    end

    // Data only on a granted response, flag only on a refused one
    always_comb begin
        bus_busy  = bus_rvalid && busy_q;
        bus_rdata = (bus_rvalid && !busy_q) ? mem_rdata : '0;
    end

endmodule

// File: rtl/cyc_wave_buf.sv
// Cyclic waveform buffer top: live recording into a ring, freeze on stop
// with post-stop count, bus snapshot readout, and bus-loaded playback into
// the processing path. Requirements R1..R11 across the submodules.
// Assumes: one sample per clock; src_mode is synchronous to clk.
module cyc_wave_buf #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 512,
    parameter int CNT_W  = 16,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_in,
    input  logic              run_start,
    input  logic              run_stop,
    input  logic              run_sync,
    input  logic              src_mode,
    input  logic [CNT_W-1:0]  post_stop_len,
    output logic [DATA_W-1:0] smp_out,
    output logic              frozen,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_busy
);

    logic              src_q;
    logic              out_src_q;
    logic [DATA_W-1:0] live_q;
    logic              rec_we;
    logic [AW-1:0]     rec_waddr;
    logic [AW-1:0]     wptr;
    logic              in_post;
    logic [AW-1:0]     play_ptr;
    logic [AW-1:0]     raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    // Mode register and live/playback output alignment (R2, R9, R11)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q     <= 1'b0;
            out_src_q <= 1'b0;
            live_q    <= '0;
        end else begin
            src_q     <= src_mode;
            out_src_q <= src_q;
            live_q    <= smp_in;
        end
    end

    // Output select between live and played samples
    always_comb smp_out = out_src_q ? mem_rdata : live_q;

    // Write port owner: recorder outside source mode, bus inside it
    always_comb begin
        mem_we    = rec_we || (src_q && bus_wr);
        mem_waddr = src_q ? bus_addr  : rec_waddr;
        mem_wdata = src_q ? bus_wdata : smp_in;
    end

    cwb_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (!src_q),
        .start    (run_start),
        .stop     (run_stop),
        .sync     (run_sync),
        .post_len (post_stop_len),
        .wr_en    (rec_we),
        .wr_addr  (rec_waddr),
        .wptr     (wptr),
        .frozen   (frozen),
        .in_post  (in_post)
    );

    cwb_play #(.DEPTH(DEPTH), .AW(AW)) i_play (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_q    (src_q),
        .sync     (run_sync),
        .play_ptr (play_ptr)
    );

    cwb_port #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) i_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .frozen     (frozen),
        .src_q      (src_q),
        .wptr       (wptr),
        .play_ptr   (play_ptr),
        .mem_rdata  (mem_rdata),
        .raddr      (raddr),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .bus_busy   (bus_busy)
    );

    cwb_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) i_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/cwb_checker.sv
// Property checker for the cyclic waveform buffer, bound to the top.
// Assumes: connected to the top's ports and its internal post-stop flag.
module cwb_checker #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] smp_in,
    input logic [DATA_W-1:0] smp_out,
    input logic              src_mode,
    input logic              run_start,
    input logic              run_stop,
    input logic              frozen,
    input logic              in_post,
    input logic              bus_rd,
    input logic              bus_rvalid,
    input logic              bus_busy,
    input logic [DATA_W-1:0] bus_rdata
);

    // R6: every read strobe gets a response on the next clock
    p_rvalid_follows_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R6: a read issued while not frozen is refused
    p_busy_unless_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !frozen) |=> bus_busy);

    // R6: a refused read carries no data
    p_busy_no_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |-> (bus_rdata == '0));

    // R2: outside source mode the output is the previous input
    p_live_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(src_mode) |=> (smp_out == $past(smp_in)));

    // R7: a snapshot stays frozen until a start
    p_freeze_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !run_start) |=> frozen);

    // R4: freezing only follows a stop or the end of the countdown
    p_freeze_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frozen) |-> ($past(run_stop) || $past(in_post)));

endmodule

bind cyc_wave_buf cwb_checker #(.DATA_W(DATA_W)) i_cwb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_in     (smp_in),
    .smp_out    (smp_out),
    .src_mode   (src_mode),
    .run_start  (run_start),
    .run_stop   (run_stop),
    .frozen     (frozen),
    .in_post    (in_post),
    .bus_rd     (bus_rd),
    .bus_rvalid (bus_rvalid),
    .bus_busy   (bus_busy),
    .bus_rdata  (bus_rdata)
);

// File: tb/test_cyc_wave_buf.sv
// Bench for the cyclic waveform buffer: a behavioural model updated at each
// rising edge and compared with every output at each falling edge.
module test_cyc_wave_buf;

    localparam int DATA_W = 10;
    localparam int DEPTH  = 512;
    localparam int CNT_W  = 16;
    localparam int AW     = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] smp_in = '0;
    logic              run_start = 1'b0, run_stop = 1'b0, run_sync = 1'b0;
    logic              src_mode = 1'b0;
    logic [CNT_W-1:0]  post_stop_len = '0;
    logic [DATA_W-1:0] smp_out;
    logic              frozen;
    logic [AW-1:0]     bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_rvalid, bus_busy;

    always #2 clk = ~clk;

    cyc_wave_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_cyc_wave_buf (.*);

    // ---------------- reference model ----------------
    int m_mem [DEPTH];
    bit m_known [DEPTH];
    int m_st, m_wptr, m_cnt, m_play, m_outsrc, m_live, m_rd;
    bit m_srcq, m_rdk, m_rvq, m_bsyq, started;
    int n_chk = 0, n_fail = 0, k_smp = 0;
    string cur = "R1";

    always @(posedge clk) begin
        int raddr, wa;
        bit osrc, rdk;
        int ord;
        started = 1'b1;
        if (!rst_n) begin
            m_st = 0; m_wptr = 0; m_cnt = 0; m_play = 0; m_srcq = 0;
            m_outsrc = 0; m_live = 0; m_rd = 0; m_rdk = 0; m_rvq = 0; m_bsyq = 0;
        end else begin
            raddr = m_srcq ? m_play : (m_wptr + int'(bus_addr)) % DEPTH;
            ord = m_mem[raddr];
            rdk = m_known[raddr];
            osrc = m_srcq;
            m_rvq = bus_rd;
            m_bsyq = bus_rd && !(m_st == 3 && !m_srcq);
            if (!m_srcq) begin
                case (m_st)
                    0: begin
                        if (run_sync) m_wptr = 0;
                        if (run_start) m_st = 1;
                    end
                    1, 2: begin
                        wa = run_sync ? 0 : m_wptr;
                        m_mem[wa] = int'(smp_in);
                        m_known[wa] = 1'b1;
                        m_wptr = (wa + 1) % DEPTH;
                        if (m_st == 1) begin
                            if (run_stop) begin
                                if (post_stop_len == 0) m_st = 3;
                                else begin m_cnt = int'(post_stop_len); m_st = 2; end
                            end
                        end else begin
                            if (m_cnt == 1) m_st = 3;
                            m_cnt = m_cnt - 1;
                        end
                    end
                    default: if (run_start) m_st = 1;
                endcase
                m_play = 0;
            end else begin
                if (bus_wr) begin
                    m_mem[bus_addr] = int'(bus_wdata);
                    m_known[bus_addr] = 1'b1;
                end
                m_play = run_sync ? 0 : (m_play + 1) % DEPTH;
            end
            m_outsrc = osrc;
            m_live = int'(smp_in);
            m_rd = ord;
            m_rdk = rdk;
            m_srcq = src_mode;
        end
    end

    task automatic chk(string sig, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur, sig, act, exp, $time);
        end
    endtask

    // Compare all outputs away from the active edge
    always @(negedge clk) begin
        if (started) begin
            if (!m_outsrc || m_rdk)
                chk("smp_out", int'(smp_out), m_outsrc ? m_rd : m_live);
            chk("frozen", int'(frozen), (m_st == 3) ? 1 : 0);
            chk("bus_rvalid", int'(bus_rvalid), int'(m_rvq));
            chk("bus_busy", int'(bus_busy), int'(m_rvq && m_bsyq));
            if (!(m_rvq && !m_bsyq) || m_rdk)
                chk("bus_rdata", int'(bus_rdata), (m_rvq && !m_bsyq) ? m_rd : 0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc();
        @(negedge clk);
        #1;
        k_smp++;
        smp_in = DATA_W'((k_smp * 37 + 11) % 1024);
        run_start = 0; run_stop = 0; run_sync = 0;
        bus_rd = 0; bus_wr = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic read_all();
        for (int a = 0; a < DEPTH; a++) begin
            cyc(); bus_rd = 1; bus_addr = AW'(a);
        end
        cyc();
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cur = "R1";
        idle(4);
        rst_n = 1;
        idle(3);
        // live path and refused reads while idle
        cur = "R2"; idle(20);
        cur = "R6"; cyc(); bus_rd = 1; bus_addr = 5; idle(3);
        // record beyond one wrap
        cur = "R3"; cyc(); run_start = 1; idle(700);
        cur = "R6"; cyc(); bus_rd = 1; bus_addr = 0; idle(2);
        // stop with post count 5, then read snapshot oldest first
        cur = "R4"; post_stop_len = 5; cyc(); run_stop = 1; idle(12);
        cur = "R5"; read_all();
        // stop/sync while frozen leave the snapshot intact
        cur = "R7"; cyc(); run_stop = 1; cyc(); run_sync = 1; idle(5); read_all();
        // resume, sync mid-run, stop with no post count
        cyc(); run_start = 1; idle(300);
        cur = "R8"; cyc(); run_sync = 1; idle(600);
        cur = "R4"; post_stop_len = 0; cyc(); run_stop = 1; idle(3);
        cur = "R8"; read_all();
        // post count 1 with a stop during the countdown
        cur = "R4"; cyc(); run_start = 1; idle(520);
        post_stop_len = 1; cyc(); run_stop = 1; cyc(); run_stop = 1; idle(4);
        cur = "R5"; read_all();
        // source mode: play the recorded ring in physical order, across the wrap
        cur = "R9"; cyc(); src_mode = 1; idle(530);
        cur = "R6"; cyc(); bus_rd = 1; bus_addr = 3; idle(2);
        // load new content, ignore converter and controls
        cur = "R9";
        for (int a = 0; a < DEPTH; a++) begin
            cyc(); bus_wr = 1; bus_addr = AW'(a); bus_wdata = DATA_W'((a * 13 + 7) % 1024);
            if (a == 100) run_start = 1;
            if (a == 200) run_stop = 1;
        end
        idle(1100);
        cur = "R10"; cyc(); run_sync = 1; idle(40); cyc(); run_sync = 1; idle(20);
        // back to live, recorder still frozen
        cur = "R11"; cyc(); src_mode = 0; idle(30);
        cyc(); bus_rd = 1; bus_addr = 9; idle(3);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule